// File: doc/BRIEF.md
# Hex-Radix Floating-Point Adder/Subtractor

This unit adds or subtracts two 32-bit floating-point words in a base-16 format: a sign bit, a 7-bit excess-64 exponent that counts powers of sixteen, and a fraction of six hexadecimal digits. A single start strobe hands it both operands and an operation bit. The unit first brings each operand to normalized form. It then orders the two by magnitude and aligns the smaller one in whole hex digits into a 32-bit guard extension. It combines the two fractions, renormalizes, rounds from the guard extension, and packs the result. A one-cycle done pulse marks a finished result.

Exponent overflow and underflow are not reported as exceptions. They produce fixed saturated or zero words together with an overflow/underflow flag. Two further flags give the sign class of the result, so a caller can use them directly as condition codes. The datapath widths and the choice between a one-step and a digit-by-digit renormalizer are parameters.

Top module: `hexfp_addsub`

## Requirements
- R1: While reset is held and after its release, `result` is 0, `done` is 0 and all three flags are 0.
- R2: Words use sign in bit 31, exponent in bits 30:24 (excess 64, radix 16) and fraction in bits 23:0. Adding two normalized operands of the same sign gives their packed sum (0x41100000 + 0x41100000 = 0x41200000).
- R3: Before use, each operand's fraction is shifted left one hex digit at a time and its exponent is decremented until the top digit is nonzero. A zero fraction becomes a clean zero (sign 0, exponent 0).
- R4: With `sub`=1 the sign of `op_b` is inverted first. When the effective signs differ, the smaller magnitude is subtracted from the larger, borrowing through the guard extension. The difference is then renormalized, and the result takes the sign of the larger magnitude.
- R5: A zero fraction in `op_a` yields the (sign-adjusted) second operand. A zero fraction in `op_b` yields the first operand.
- R6: The smaller magnitude (compared by exponent, then by fraction) is shifted right by four bits per unit of exponent difference. A difference above 14 discards it entirely.
- R7: A same-sign sum that carries out of the 24-bit fraction is shifted right one hex digit, and its exponent is incremented.
- R8: When the top guard bit is set, 1 is added to the fraction. A carry out of that increment shifts right one hex digit and increments the exponent.
- R9: A final exponent of 0 or below gives `result` 0 with `flag_ovf`=1 and the other flags 0.
- R10: A final exponent above 127 gives `result` = {sign, 31 ones} with `flag_ovf`=1, plus `flag_lt` for a negative sign or `flag_gt` for a positive one.
- R11: A zero fraction after rounding gives `result` 0 with no flags. Any other in-range result raises `flag_lt` if negative and `flag_gt` if positive, never both.
- R12: `start` is accepted only while idle; a start during an operation is ignored. Each accepted start gives exactly one single-cycle `done` pulse. `result` and the flags hold from that pulse until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| sub | input | 1 | 1 = op_a minus op_b, 0 = op_a plus op_b |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| result | output | 32 | Packed result word |
| done | output | 1 | One-cycle pulse when a result is ready |
| flag_lt | output | 1 | Result negative (or negative overflow) |
| flag_gt | output | 1 | Result positive and nonzero (or positive overflow) |
| flag_ovf | output | 1 | Exponent overflow or underflow |

## Verification
The bench keeps the default word geometry (7-bit exponent, six fraction digits, eight guard digits) but overrides `FAST_NORM` to 0. This selects the renormalizer that moves one hex digit per cycle, so operation latency depends on data. Deep cancellations, such as a borrow that runs through the guard extension, then occupy many cycles in the normalize loop. That stretches the window in which stray starts must be ignored and makes a completion-driven scoreboard necessary. The default single-step variant uses the same datapath and differs only in how many digits it moves per pass.

// File: rtl/hexfp_pkg.sv
`timescale 1ns/1ps
package hexfp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CALC,
      ST_NORM,
      ST_PACK
   } hexfp_state_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic ovf;
   } hexfp_flags_t;

endpackage

// File: rtl/hexfp_prenorm.sv
`timescale 1ns/1ps
// Normalizes one packed operand: strips leading zero hex digits and
// lowers the exponent to match; a zero fraction becomes a clean zero.
module hexfp_prenorm #(
   parameter  int EXP_W       = 7,
   parameter  int FRAC_DIGITS = 6,
   parameter  int XEXP_W      = 12,
   localparam int FRAC_W      = 4 * FRAC_DIGITS,
   localparam int WORD_W      = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0]        word_i,
   output logic                     sign_o,
   output logic signed [XEXP_W-1:0] exp_o,
   output logic [FRAC_W-1:0]        frac_o,
   output logic                     zero_o
);

   logic [FRAC_W-1:0] raw_frac;
   logic [EXP_W-1:0]  raw_exp;
   logic              seen;
   int                lead;

   assign raw_frac = word_i[FRAC_W-1:0];
   assign raw_exp  = word_i[WORD_W-2:FRAC_W];

   always_comb begin
      lead = 0;
      seen = 1'b0;
      for (int d = FRAC_DIGITS - 1; d >= 0; d--) begin
         if (!seen) begin
            if (raw_frac[4*d +: 4] != 4'h0) seen = 1'b1;
            else                            lead = lead + 1;
         end
      end
      zero_o = ~seen;
      if (seen) begin
         sign_o = word_i[WORD_W-1];
         frac_o = raw_frac << (4 * lead);
         exp_o  = $signed({{(XEXP_W-EXP_W){1'b0}}, raw_exp}) - XEXP_W'(lead);
      end else begin
         sign_o = 1'b0;
         frac_o = '0;
         exp_o  = '0;
      end
   end

endmodule

// File: rtl/hexfp_align.sv
`timescale 1ns/1ps
// Orders the operands by magnitude, aligns the smaller one in whole
// hex digits into the guard extension and adds or subtracts.
module hexfp_align #(
   parameter  int FRAC_DIGITS  = 6,
   parameter  int GUARD_DIGITS = 8,
   parameter  int XEXP_W       = 12,
   localparam int FRAC_W       = 4 * FRAC_DIGITS,
   localparam int GUARD_W      = 4 * GUARD_DIGITS,
   localparam int TOT_DIGITS   = FRAC_DIGITS + GUARD_DIGITS,
   localparam int MAG_W        = 4 * TOT_DIGITS,
   localparam int MW           = MAG_W + 1
) (
   input  logic                     sub_i,
   input  logic                     sign_a_i,
   input  logic signed [XEXP_W-1:0] exp_a_i,
   input  logic [FRAC_W-1:0]        frac_a_i,
   input  logic                     zero_a_i,
   input  logic                     sign_b_i,
   input  logic signed [XEXP_W-1:0] exp_b_i,
   input  logic [FRAC_W-1:0]        frac_b_i,
   input  logic                     zero_b_i,
   output logic                     sign_o,
   output logic signed [XEXP_W-1:0] exp_o,
   output logic [MW-1:0]            mant_o
);

   localparam logic [GUARD_W-1:0] GZERO = '0;

   logic                     sign_b_eff;
   logic                     swap;
   logic                     sg_big, sg_small;
   logic signed [XEXP_W-1:0] ex_big, ex_small;
   logic [FRAC_W-1:0]        fr_big, fr_small;
   logic [MAG_W-1:0]         mag_big, mag_small;
   int                       ediff;

   always_comb begin
      sign_b_eff = sign_b_i ^ sub_i;
      swap = (exp_a_i < exp_b_i) || ((exp_a_i == exp_b_i) && (frac_a_i < frac_b_i));
      sg_big   = swap ? sign_b_eff : sign_a_i;
      sg_small = swap ? sign_a_i   : sign_b_eff;
      ex_big   = swap ? exp_b_i    : exp_a_i;
      ex_small = swap ? exp_a_i    : exp_b_i;
      fr_big   = swap ? frac_b_i   : frac_a_i;
      fr_small = swap ? frac_a_i   : frac_b_i;
      ediff    = int'(ex_big) - int'(ex_small);
      mag_big  = {fr_big, GZERO};
      if ((ediff < 0) || (ediff > TOT_DIGITS)) mag_small = '0;
      else mag_small = {fr_small, GZERO} >> (4 * ediff);

      if (zero_a_i) begin
         sign_o = sign_b_eff;
         exp_o  = exp_b_i;
         mant_o = {1'b0, frac_b_i, GZERO};
      end else if (zero_b_i) begin
         sign_o = sign_a_i;
         exp_o  = exp_a_i;
         mant_o = {1'b0, frac_a_i, GZERO};
      end else begin
         sign_o = sg_big;
         exp_o  = ex_big;
         if (sg_big != sg_small) mant_o = {1'b0, mag_big} - {1'b0, mag_small};
         else                    mant_o = {1'b0, mag_big} + {1'b0, mag_small};
      end
   end

endmodule

// File: rtl/hexfp_postnorm.sv
`timescale 1ns/1ps
// One renormalization pass. A carry digit is always folded back in a
// single pass; leading zero digits are removed all at once
// (FAST_NORM=1) or one per pass (FAST_NORM=0).
module hexfp_postnorm #(
   parameter  int TOT_DIGITS = 14,
   parameter  int XEXP_W     = 12,
   parameter  bit FAST_NORM  = 1'b1,
   localparam int MAG_W      = 4 * TOT_DIGITS,
   localparam int MW         = MAG_W + 1
) (
   input  logic signed [XEXP_W-1:0] exp_i,
   input  logic [MW-1:0]            mant_i,
   output logic signed [XEXP_W-1:0] exp_o,
   output logic [MW-1:0]            mant_o,
   output logic                     settled_o
);

   logic                     top_nz;
   logic                     carry;
   logic signed [XEXP_W-1:0] step_exp;
   logic [MW-1:0]            step_mant;

   assign top_nz = (mant_i[MAG_W-1 -: 4] != 4'h0);
   assign carry  = mant_i[MW-1];

   generate
      if (FAST_NORM) begin : g_fast
         int lead;
         logic seen;
         always_comb begin
            lead = 0;
            seen = 1'b0;
            for (int d = TOT_DIGITS - 1; d >= 0; d--) begin
               if (!seen) begin
                  if (mant_i[4*d +: 4] != 4'h0) seen = 1'b1;
                  else                          lead = lead + 1;
               end
            end
            step_mant = mant_i << (4 * lead);
            step_exp  = exp_i - XEXP_W'(lead);
         end
      end else begin : g_iter
         always_comb begin
            step_mant = mant_i << 4;
            step_exp  = exp_i - XEXP_W'(1);
         end
      end
   endgenerate

   always_comb begin
      if (carry) begin
         mant_o    = mant_i >> 4;
         exp_o     = exp_i + XEXP_W'(1);
         settled_o = 1'b1;
      end else if ((mant_i == '0) || top_nz) begin
         mant_o    = mant_i;
         exp_o     = exp_i;
         settled_o = 1'b1;
      end else begin
         mant_o    = step_mant;
         exp_o     = step_exp;
         settled_o = FAST_NORM;
      end
   end

endmodule

// File: rtl/hexfp_round_pack.sv
`timescale 1ns/1ps
// Rounds from the top guard bit, then packs with zero, underflow and
// overflow handling and derives the three flags.
module hexfp_round_pack #(
   parameter  int EXP_W       = 7,
   parameter  int FRAC_DIGITS = 6,
   parameter  int XEXP_W      = 12,
   localparam int FRAC_W      = 4 * FRAC_DIGITS,
   localparam int WORD_W      = 1 + EXP_W + FRAC_W
) (
   input  logic                     sign_i,
   input  logic signed [XEXP_W-1:0] exp_i,
   input  logic [FRAC_W-1:0]        frac_i,
   input  logic                     rnd_i,
   output logic [WORD_W-1:0]        word_o,
   output hexfp_pkg::hexfp_flags_t  flags_o
);

   localparam logic signed [XEXP_W-1:0] EXP_TOP = XEXP_W'((1 << EXP_W) - 1);

   logic [FRAC_W:0]          sum;
   logic [FRAC_W-1:0]        frac_r;
   logic signed [XEXP_W-1:0] exp_r;

   always_comb begin
      sum = {1'b0, frac_i} + (FRAC_W+1)'(rnd_i);
      if (sum[FRAC_W]) begin
         frac_r = FRAC_W'(sum >> 4);
         exp_r  = exp_i + XEXP_W'(1);
      end else begin
         frac_r = sum[FRAC_W-1:0];
         exp_r  = exp_i;
      end

      if (frac_r == '0) begin
         word_o  = '0;
         flags_o = '{lt: 1'b0, gt: 1'b0, ovf: 1'b0};
      end else if (exp_r <= 0) begin
         word_o  = '0;
         flags_o = '{lt: 1'b0, gt: 1'b0, ovf: 1'b1};
      end else if (exp_r > EXP_TOP) begin
         word_o  = {sign_i, {(WORD_W-1){1'b1}}};
         flags_o = '{lt: sign_i, gt: ~sign_i, ovf: 1'b1};
      end else begin
         word_o  = {sign_i, exp_r[EXP_W-1:0], frac_r};
         flags_o = '{lt: sign_i, gt: ~sign_i, ovf: 1'b0};
      end
   end

endmodule

// File: rtl/hexfp_addsub.sv
`timescale 1ns/1ps
// Sequential hex-radix floating-point add/subtract unit.
module hexfp_addsub #(
   parameter  int EXP_W        = 7,
   parameter  int FRAC_DIGITS  = 6,
   parameter  int GUARD_DIGITS = 8,
   parameter  bit FAST_NORM    = 1'b1,
   localparam int WORD_W       = 1 + EXP_W + 4 * FRAC_DIGITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sub,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic [WORD_W-1:0] result,
   output logic              done,
   output logic              flag_lt,
   output logic              flag_gt,
   output logic              flag_ovf
);
   import hexfp_pkg::*;

   localparam int FRAC_W     = 4 * FRAC_DIGITS;
   localparam int GUARD_W    = 4 * GUARD_DIGITS;
   localparam int TOT_DIGITS = FRAC_DIGITS + GUARD_DIGITS;
   localparam int MAG_W      = 4 * TOT_DIGITS;
   localparam int MW         = MAG_W + 1;
   localparam int XEXP_W     = EXP_W + $clog2(TOT_DIGITS + 2) + 2;

   if (EXP_W < 2) begin : g_chk_exp
      $error("hexfp_addsub: EXP_W must be at least 2");
   end
   if (FRAC_DIGITS < 2) begin : g_chk_frac
      $error("hexfp_addsub: FRAC_DIGITS must be at least 2");
   end
   if (GUARD_DIGITS < 1) begin : g_chk_guard
      $error("hexfp_addsub: GUARD_DIGITS must be at least 1");
   end

   hexfp_state_e             state_q;
   logic [WORD_W-1:0]        opnd_q [2];
   logic                     sub_q;
   logic                     sign_q;
   logic signed [XEXP_W-1:0] exp_q;
   logic [MW-1:0]            mant_q;
   logic [WORD_W-1:0]        result_q;
   hexfp_flags_t             flags_q;
   logic                     done_q;

   logic                     pn_sign [2];
   logic signed [XEXP_W-1:0] pn_exp  [2];
   logic [FRAC_W-1:0]        pn_frac [2];
   logic                     pn_zero [2];

   generate
      for (genvar i = 0; i < 2; i++) begin : g_pre
         hexfp_prenorm #(
            .EXP_W      (EXP_W),
            .FRAC_DIGITS(FRAC_DIGITS),
            .XEXP_W     (XEXP_W)
         ) u_prenorm (
            .word_i(opnd_q[i]),
            .sign_o(pn_sign[i]),
            .exp_o (pn_exp[i]),
            .frac_o(pn_frac[i]),
            .zero_o(pn_zero[i])
         );
      end
   endgenerate

   logic                     al_sign;
   logic signed [XEXP_W-1:0] al_exp;
   logic [MW-1:0]            al_mant;

   hexfp_align #(
      .FRAC_DIGITS (FRAC_DIGITS),
      .GUARD_DIGITS(GUARD_DIGITS),
      .XEXP_W      (XEXP_W)
   ) u_align (
      .sub_i   (sub_q),
      .sign_a_i(pn_sign[0]),
      .exp_a_i (pn_exp[0]),
      .frac_a_i(pn_frac[0]),
      .zero_a_i(pn_zero[0]),
      .sign_b_i(pn_sign[1]),
      .exp_b_i (pn_exp[1]),
      .frac_b_i(pn_frac[1]),
      .zero_b_i(pn_zero[1]),
      .sign_o  (al_sign),
      .exp_o   (al_exp),
      .mant_o  (al_mant)
   );

   logic signed [XEXP_W-1:0] nm_exp;
   logic [MW-1:0]            nm_mant;
   logic                     nm_settled;

   hexfp_postnorm #(
      .TOT_DIGITS(TOT_DIGITS),
      .XEXP_W    (XEXP_W),
      .FAST_NORM (FAST_NORM)
   ) u_postnorm (
      .exp_i    (exp_q),
      .mant_i   (mant_q),
      .exp_o    (nm_exp),
      .mant_o   (nm_mant),
      .settled_o(nm_settled)
   );

   logic [WORD_W-1:0] pk_word;
   hexfp_flags_t      pk_flags;

   hexfp_round_pack #(
      .EXP_W      (EXP_W),
      .FRAC_DIGITS(FRAC_DIGITS),
      .XEXP_W     (XEXP_W)
   ) u_pack (
      .sign_i (sign_q),
      .exp_i  (exp_q),
      .frac_i (mant_q[MAG_W-1 -: FRAC_W]),
      .rnd_i  (mant_q[GUARD_W-1]),
      .word_o (pk_word),
      .flags_o(pk_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         opnd_q[0] <= '0;
         opnd_q[1] <= '0;
         sub_q     <= 1'b0;
         sign_q    <= 1'b0;
         exp_q     <= '0;
         mant_q    <= '0;
         result_q  <= '0;
         flags_q   <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  opnd_q[0] <= op_a;
                  opnd_q[1] <= op_b;
                  sub_q     <= sub;
                  state_q   <= ST_CALC;
               end
            end
            ST_CALC: begin
               sign_q  <= al_sign;
               exp_q   <= al_exp;
               mant_q  <= al_mant;
               state_q <= ST_NORM;
            end
            ST_NORM: begin
               exp_q  <= nm_exp;
               mant_q <= nm_mant;
               if (nm_settled) state_q <= ST_PACK;
            end
            ST_PACK: begin
               result_q <= pk_word;
               flags_q  <= pk_flags;
               done_q   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign result   = result_q;
   assign done     = done_q;
   assign flag_lt  = flags_q.lt;
   assign flag_gt  = flags_q.gt;
   assign flag_ovf = flags_q.ovf;

endmodule

// File: rtl/hexfp_addsub_chk.sv
`timescale 1ns/1ps
module hexfp_addsub_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic [WORD_W-1:0] result,
   input logic              flag_lt,
   input logic              flag_gt,
   input logic              flag_ovf
);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(flag_lt) && $stable(flag_gt) && $stable(flag_ovf)));

   assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_lt && flag_gt));

   assert_zero_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (result[WORD_W-2:0] == '0) |-> (!flag_lt && !flag_gt));

   assert_sign_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (result[WORD_W-2:0] != '0) |-> ((flag_lt == result[WORD_W-1]) && (flag_gt == !result[WORD_W-1])));

   assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ovf && (result != '0)) |-> (result[WORD_W-2:0] == '1));

endmodule

bind hexfp_addsub hexfp_addsub_chk #(.WORD_W(WORD_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done    (done),
   .result  (result),
   .flag_lt (flag_lt),
   .flag_gt (flag_gt),
   .flag_ovf(flag_ovf)
);

// File: tb/hexfp_addsub_bench.sv
`timescale 1ns/1ps
module hexfp_addsub_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sub = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [31:0] result;
   logic        done;
   logic        flag_lt, flag_gt, flag_ovf;

   always #2.5 clk = ~clk;

   hexfp_addsub #(.FAST_NORM(1'b0)) u_hexfp_addsub (
      .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
      .op_a(op_a), .op_b(op_b), .result(result), .done(done),
      .flag_lt(flag_lt), .flag_gt(flag_gt), .flag_ovf(flag_ovf)
   );

   typedef struct {
      logic [34:0] val;  // {word, lt, gt, ovf}
      string       tag;
   } item_t;

   item_t sb_q[$];
   int checks = 0;
   int fails = 0;
   int dones = 0;
   int issued = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic void unpk(input logic [31:0] w, output bit sg, output int ex,
                                output longint unsigned fr);
      fr = 64'(w[23:0]);
      if (fr == 0) begin
         sg = 1'b0; ex = 0;
      end else begin
         sg = w[31]; ex = int'(w[30:24]);
         while (((fr >> 20) & 15) == 0) begin fr = fr << 4; ex--; end
      end
   endfunction

   // Expected value built from the requirements
   function automatic logic [34:0] ref_op(input logic [31:0] a, input logic [31:0] b, input logic s);
      bit sa, sb, sr, st;
      int ea, eb, er, et, ed;
      longint unsigned fa, fb, ft, m, sm, fr;
      logic [6:0] ebits;
      unpk(a, sa, ea, fa);
      unpk(b, sb, eb, fb);
      sb = sb ^ s;
      if (fa == 0) begin
         sr = sb; er = eb; m = fb << 32;
      end else if (fb == 0) begin
         sr = sa; er = ea; m = fa << 32;
      end else begin
         if ((ea < eb) || ((ea == eb) && (fa < fb))) begin
            st = sa; sa = sb; sb = st;
            et = ea; ea = eb; eb = et;
            ft = fa; fa = fb; fb = ft;
         end
         ed = ea - eb;
         sm = (ed > 14) ? 64'd0 : ((fb << 32) >> (4 * ed));
         sr = sa; er = ea;
         if (sa != sb) begin
            m = (fa << 32) - sm;
            if (m != 0) while (((m >> 52) & 15) == 0) begin m = m << 4; er--; end
         end else begin
            m = (fa << 32) + sm;
            if (((m >> 56) & 1) != 0) begin m = m >> 4; er++; end
         end
      end
      fr = m >> 32;
      if (((m >> 31) & 1) != 0) begin
         fr = fr + 1;
         if (((fr >> 24) & 1) != 0) begin fr = fr >> 4; er++; end
      end
      if (fr == 0) return {32'h0, 3'b000};
      if (er <= 0) return {32'h0, 3'b001};
      if (er > 127) return sr ? {32'hFFFFFFFF, 3'b101} : {32'h7FFFFFFF, 3'b011};
      ebits = 7'(er);
      return {sr, ebits, fr[23:0], sr, ~sr, 1'b0};
   endfunction

   task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic s);
      @(negedge clk);
      op_a = a; op_b = b; sub = s; start = 1'b1;
      issued++;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
   endtask

   task automatic issue_exp(input logic [31:0] a, input logic [31:0] b, input logic s,
                            input logic [31:0] w, input logic [2:0] f, input string tag);
      item_t it;
      it.val = {w, f};
      it.tag = tag;
      sb_q.push_back(it);
      drive(a, b, s);
   endtask

   task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s, input string tag);
      item_t it;
      it.val = ref_op(a, b, s);
      it.tag = tag;
      sb_q.push_back(it);
      drive(a, b, s);
   endtask

   // Monitor: pop the expected item on each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         dones++;
         if (sb_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R12 unexpected done actual=1 expected=0");
         end else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, 64'({result, flag_lt, flag_gt, flag_ovf}), 64'(it.val));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] ra, rb, held;
      repeat (3) @(negedge clk);
      check("R1 reset result", 64'(result), 64'h0);
      check("R1 reset done/flags", 64'({done, flag_lt, flag_gt, flag_ovf}), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after release", 64'({result, done, flag_lt, flag_gt, flag_ovf}), 64'h0);

      issue_exp(32'h41100000, 32'h41100000, 1'b0, 32'h41200000, 3'b010, "R2 1+1");
      issue_exp(32'h41800000, 32'h41800000, 1'b0, 32'h42100000, 3'b010, "R7 carry out");
      issue_exp(32'h41100000, 32'h41100000, 1'b1, 32'h00000000, 3'b000, "R4 R11 x-x zero");
      issue_exp(32'h41100000, 32'hC0800000, 1'b0, 32'h40800000, 3'b010, "R4 mixed signs");
      issue_exp(32'h41100000, 32'h40800000, 1'b1, 32'h40800000, 3'b010, "R4 subtract");
      issue_exp(32'h40800000, 32'h41100000, 1'b1, 32'hC0800000, 3'b100, "R4 swap sign");
      issue_exp(32'h47100000, 32'h41800000, 1'b1, 32'h46FFFFF8, 3'b010, "R4 guard borrow");
      issue_exp(32'h42010000, 32'h00000000, 1'b0, 32'h41100000, 3'b010, "R3 R5 unnormalized a");
      issue_exp(32'h00000000, 32'h41100000, 1'b1, 32'hC1100000, 3'b100, "R5 R4 zero a");
      issue_exp(32'h40000000, 32'h41100000, 1'b0, 32'h41100000, 3'b010, "R5 zero frac a");
      issue_exp(32'h50100000, 32'h41100000, 1'b0, 32'h50100000, 3'b010, "R6 diff 15 dropped");
      issue_exp(32'h48100000, 32'h41800000, 1'b0, 32'h48100000, 3'b010, "R6 diff 7");
      issue_exp(32'h47100000, 32'h41800000, 1'b0, 32'h47100001, 3'b010, "R8 round up");
      issue_exp(32'h47FFFFFF, 32'h41800000, 1'b0, 32'h48100000, 3'b010, "R8 round carry");
      issue_exp(32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 32'h7FFFFFFF, 3'b011, "R10 pos overflow");
      issue_exp(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFFF, 3'b101, "R10 neg overflow");
      issue_exp(32'h00100000, 32'h00080000, 1'b1, 32'h00000000, 3'b001, "R9 underflow");
      issue_exp(32'h00010000, 32'h00000000, 1'b0, 32'h00000000, 3'b001, "R9 R3 prenorm underflow");
      issue_exp(32'hC1100000, 32'hC1100000, 1'b0, 32'hC1200000, 3'b100, "R11 negative");

      // R12: starts during an operation are ignored
      begin
         item_t it;
         it.val = {32'h41200000, 3'b010};
         it.tag = "R12 busy start ignored";
         sb_q.push_back(it);
         @(negedge clk);
         op_a = 32'h41100000; op_b = 32'h41100000; sub = 1'b0; start = 1'b1;
         issued++;
         @(negedge clk);
         op_a = 32'h7FFFFFFF; op_b = 32'h7FFFFFFF; sub = 1'b1;
         @(negedge clk);
         @(negedge clk);
         start = 1'b0;
         while (!done) @(negedge clk);
         held = result;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R12 no extra done", 64'(done), 64'h0);
         end
         check("R12 result held", 64'({result, flag_lt, flag_gt, flag_ovf}), 64'({held, 3'b010}));
      end

      for (int i = 0; i < 300; i++) begin
         ra = $urandom;
         rb = $urandom;
         if (i % 2 == 1) rb[30:24] = ra[30:24] + 7'($urandom % 5) - 7'd2;
         if (i % 7 == 0) rb[23:0] = ra[23:0];
         if (i % 11 == 0) rb[31] = ~ra[31];
         issue(ra, rb, 1'($urandom % 2), "R2 R4 R6 random");
      end

      repeat (5) @(negedge clk);
      check("R12 one done per start", 64'(dones), 64'(issued));
      check("R12 scoreboard drained", 64'(sb_q.size()), 64'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule